// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block produces the effective operand address for an 18-bit word machine with a 17-bit (128K word) physical memory. The address is built by splicing bit fields, not by plain addition. Bit numbering throughout follows the machine convention: bit 0 is the most significant bit of an 18-bit word, so machine bit n sits at vector position 17-n. A request carries the instruction word, the program counter, a page/bank mode flag and the 18-bit index register. It is accepted over a valid/ready handshake. The block may then fetch a pointer word over its memory port. For an auto-increment cell, it also writes the updated pointer back. Finally it presents the 17-bit address on a valid/ready output.

Instruction fields: machine bit 4 is the pointer flag. In page mode, machine bit 5 is the index flag and bits 6–17 (12 bits) are the operand. In bank mode, bits 5–17 (13 bits) are the operand and there is no index flag.

Back-pressure rules:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no request is in flight.
- A memory access is offered with `mem_req` and completes on an edge where `mem_ready` is also high. Read data is taken from `mem_rdata` in that same cycle.
- The result stays on `ea` with `ea_valid` high until an edge where `ea_ready` is high. The block becomes ready for a new request on the following cycle.

Top module: `seg_ea_gen`

## Requirements
- R1: Page mode with the pointer flag (machine bit 4, vector bit 13) clear and the index flag (machine bit 5, vector bit 12) clear gives an address made of program-counter bits 0–5 followed by instruction bits 6–17, with no memory access. Example: PC 274567 and instruction 203212 give 273212 (octal).
- R2: Bank mode with the pointer flag clear gives program-counter bits 0–4 followed by instruction bits 5–17, with no memory access.
- R3: With the pointer flag set and the operand outside the cell range, one read is made at the R1/R2 direct address, and nothing is written. The address is program-counter bits 1–2 followed by the low 15 bits of the word read.
- R4: A reference uses an auto-increment cell only when the pointer flag is set and the operand value (12-bit in page mode, 13-bit in bank mode) lies in octal 10–17. The cell is then read at that absolute location, whatever the program counter holds.
- R5: For a cell reference, the word read plus one (modulo 2^18) is written back to the same cell in a separate access. That incremented value, as a full 17-bit address with no block splice, is the result.
- R6: In page mode with the index flag set and the pointer flag clear, the result is the direct address plus the index register in two's complement, truncated to 17 bits. This includes a zero operand and negative index values.
- R7: In page mode with both flags set, the index register is added to the cell result or the pointer result, truncated to 17 bits.
- R8: In bank mode, machine bit 5 is only an operand bit. The index register never affects the result.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until `mem_ready` completes the access. No access is made that the request does not call for.
- R10: Once raised, `ea_valid` and `ea` stay unchanged until `ea_ready` is seen.
- R11: During reset `req_ready` is high while `ea_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_instr | input | 18 | Instruction word |
| req_pc | input | 18 | Program counter |
| req_bank_mode | input | 1 | 1 = bank mode, 0 = page mode |
| req_xr | input | 18 | Index register, two's complement |
| mem_req | output | 1 | Memory access offered |
| mem_we | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | 17 | Memory word address |
| mem_wdata | output | 18 | Write-back data |
| mem_rdata | input | 18 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the offered access |
| ea_valid | output | 1 | Result present |
| ea_ready | input | 1 | Consumer takes the result |
| ea | output | 17 | Effective address |

## Verification
The bench builds the block with its default parameters: an 18-bit word, a 17-bit address, 12- and 13-bit operand fields, a 2-bit block field and eight cells starting at octal 10. With these values the interesting edges are all within reach:
- an auto-increment cell holding 777777 wraps to zero;
- a cell holding 177777 points beyond the current block;
- a negative index lands below the page base;
- operands 7 and 20 sit just outside the cell range.

Random ready stalls on both the memory and the output side exercise every hold rule.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WBACK = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic via_ptr;    // pointer flag set: one memory read needed
    logic via_cell;   // pointer goes through an auto-increment cell
    logic add_index;  // index register is added at the end
  } ref_kind_t;
endpackage

// File: rtl/seg_ea_decode.sv
module seg_ea_decode
  import seg_ea_pkg::*;
#(
  parameter int W       = 18,
  parameter int AW      = 17,
  parameter int PG_OFF  = 12,
  parameter int BK_OFF  = 13,
  parameter int CELL_LO = 8,
  parameter int CELL_N  = 8
) (
  input  logic [BK_OFF:0]       instr_lo,   // vector bits BK_OFF..0 of the instruction
  input  logic [W-PG_OFF-1:0]   pc_hi,      // program-counter bits above the page offset
  input  logic                  bank_mode,
  output ref_kind_t             kind,
  output logic [W-1:0]          near_word,
  output logic [AW-1:0]         fetch_addr
);
  localparam int PTR_POS = BK_OFF;       // machine bit 4
  localparam int IDX_POS = BK_OFF - 1;   // machine bit 5
  localparam int BK_HI   = W - BK_OFF;

  logic [BK_OFF-1:0] opnd;
  logic [W-1:0]      pg_word, bk_word;
  logic              in_cells;

  assign pg_word = {pc_hi, instr_lo[PG_OFF-1:0]};
  assign bk_word = {pc_hi[W-PG_OFF-1 -: BK_HI], instr_lo[BK_OFF-1:0]};
  assign opnd    = bank_mode ? instr_lo[BK_OFF-1:0]
                             : {{(BK_OFF-PG_OFF){1'b0}}, instr_lo[PG_OFF-1:0]};

  assign in_cells = (opnd >= BK_OFF'(CELL_LO)) &&
                    (opnd <= BK_OFF'(CELL_LO + CELL_N - 1));

  always_comb begin
    kind.via_ptr   = instr_lo[PTR_POS];
    kind.via_cell  = instr_lo[PTR_POS] && in_cells;
    kind.add_index = !bank_mode && instr_lo[IDX_POS];
    near_word      = bank_mode ? bk_word : pg_word;
    fetch_addr     = kind.via_cell ? AW'(opnd) : near_word[AW-1:0];
  end
endmodule

// File: rtl/seg_ea_form.sv
module seg_ea_form #(
  parameter int W     = 18,
  parameter int AW    = 17,
  parameter int BLK_W = 2
) (
  input  logic              via_ptr,
  input  logic              via_cell,
  input  logic              add_index,
  input  logic [W-1:0]      near_word,
  input  logic [BLK_W-1:0]  blk,
  input  logic [W-1:0]      ptr_word,
  input  logic [W-1:0]      xr,
  output logic [AW-1:0]     ea
);
  localparam int SPLICE_W = AW - BLK_W;

  logic [W-1:0] base, sum;
  logic         unused_carry;

  always_comb begin
    if (!via_ptr)      base = near_word;
    else if (via_cell) base = ptr_word;
    else               base = W'({blk, ptr_word[SPLICE_W-1:0]});
    sum = add_index ? base + xr : base;
  end

  assign ea           = sum[AW-1:0];
  assign unused_carry = ^sum[W-1:AW];
endmodule

// File: rtl/seg_ea_seq.sv
module seg_ea_seq
  import seg_ea_pkg::*;
#(
  parameter int W  = 18,
  parameter int AW = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           start_ptr,
  input  logic           hit_cell,
  input  logic [AW-1:0]  fetch_addr,
  input  logic           mem_ready,
  input  logic [W-1:0]   mem_rdata,
  input  logic           ea_ready,
  output logic           req_ready,
  output logic           ea_valid,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [W-1:0]   mem_wdata,
  output logic [W-1:0]   ptr_word
);
  seq_state_e state_q;
  logic [W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (req_valid) state_q <= start_ptr ? ST_READ : ST_DONE;
        ST_READ:  if (mem_ready) begin
                    ptr_q   <= hit_cell ? mem_rdata + 1'b1 : mem_rdata;
                    state_q <= hit_cell ? ST_WBACK : ST_DONE;
                  end
        ST_WBACK: if (mem_ready) state_q <= ST_DONE;
        ST_DONE:  if (ea_ready) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ea_valid  = (state_q == ST_DONE);
  assign mem_req   = (state_q == ST_READ) || (state_q == ST_WBACK);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = fetch_addr;
  assign mem_wdata = ptr_q;
  assign ptr_word  = ptr_q;

  // R9: an offered access is held until accepted
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

  // R5: write-back targets the cell that was just read
  a_r5_wb_same_cell: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $stable(mem_addr));

  // R5: write-back data is the read word plus one
  a_r5_wb_increment: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> (mem_wdata == W'($past(mem_rdata) + 1'b1)));
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int W       = 18,
  parameter int AW      = 17,
  parameter int PG_OFF  = 12,
  parameter int BK_OFF  = 13,
  parameter int BLK_W   = 2,
  parameter int CELL_LO = 8,
  parameter int CELL_N  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [W-1:0]   req_instr,
  input  logic [W-1:0]   req_pc,
  input  logic           req_bank_mode,
  input  logic [W-1:0]   req_xr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  input  logic           mem_ready,
  output logic           ea_valid,
  input  logic           ea_ready,
  output logic [AW-1:0]  ea
);
  ref_kind_t         kind_d, kind_q;
  logic [W-1:0]      near_d, near_q;
  logic [AW-1:0]     fetch_d, fetch_q;
  logic [BLK_W-1:0]  blk_q;
  logic [W-1:0]      xr_q;
  logic [W-1:0]      ptr_word;
  logic              take;
  logic              unused_fields;

  assign unused_fields = ^{req_pc[PG_OFF-1:0], req_instr[W-1:BK_OFF+1]};
  assign take          = req_valid && req_ready;

  seg_ea_decode #(
    .W(W), .AW(AW), .PG_OFF(PG_OFF), .BK_OFF(BK_OFF),
    .CELL_LO(CELL_LO), .CELL_N(CELL_N)
  ) u_decode (
    .instr_lo   (req_instr[BK_OFF:0]),
    .pc_hi      (req_pc[W-1:PG_OFF]),
    .bank_mode  (req_bank_mode),
    .kind       (kind_d),
    .near_word  (near_d),
    .fetch_addr (fetch_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= '0;
      near_q  <= '0;
      fetch_q <= '0;
      blk_q   <= '0;
      xr_q    <= '0;
    end else if (take) begin
      kind_q  <= kind_d;
      near_q  <= near_d;
      fetch_q <= fetch_d;
      blk_q   <= req_pc[AW-1 -: BLK_W];
      xr_q    <= req_xr;
    end
  end

  seg_ea_seq #(.W(W), .AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .start_ptr  (kind_d.via_ptr),
    .hit_cell   (kind_q.via_cell),
    .fetch_addr (fetch_q),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .ea_ready   (ea_ready),
    .req_ready  (req_ready),
    .ea_valid   (ea_valid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .ptr_word   (ptr_word)
  );

  seg_ea_form #(.W(W), .AW(AW), .BLK_W(BLK_W)) u_form (
    .via_ptr   (kind_q.via_ptr),
    .via_cell  (kind_q.via_cell),
    .add_index (kind_q.add_index),
    .near_word (near_q),
    .blk       (blk_q),
    .ptr_word  (ptr_word),
    .xr        (xr_q),
    .ea        (ea)
  );

  // R10: result held under back-pressure
  a_r10_ea_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !ea_ready) |=> (ea_valid && $stable(ea)));

  // R4: writes only ever land on auto-increment cells
  a_r4_write_cells: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_addr >= AW'(CELL_LO)) &&
                             (mem_addr <= AW'(CELL_LO + CELL_N - 1))));

  // R1: a reference without the pointer flag never touches memory
  a_r1_direct_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> kind_q.via_ptr);

  // R9: write-back only for cell references
  a_r9_wb_only_cells: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> kind_q.via_cell);
endmodule

// File: tb/seg_ea_gen_test.sv
`timescale 1ns/1ps
module seg_ea_gen_test;
  localparam int W  = 18;
  localparam int AW = 17;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [W-1:0]   req_instr = '0, req_pc = '0, req_xr = '0;
  logic           req_bank_mode = 1'b0;
  logic           mem_req, mem_we;
  logic [AW-1:0]  mem_addr;
  logic [W-1:0]   mem_wdata;
  logic [W-1:0]   mem_rdata = '0;
  logic           mem_ready = 1'b0;
  logic           ea_valid;
  logic           ea_ready = 1'b0;
  logic [AW-1:0]  ea;

  seg_ea_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_instr(req_instr), .req_pc(req_pc), .req_bank_mode(req_bank_mode),
    .req_xr(req_xr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .ea_valid(ea_valid), .ea_ready(ea_ready), .ea(ea)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          we;
    logic [W-1:0]  data;
    string         tag;
  } acc_t;

  acc_t          acc_q[$];
  logic [AW-1:0] ea_q[$];
  string         tag_q[$];
  logic [W-1:0]  mem [int unsigned];

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  function automatic logic [W-1:0] peek(input logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return W'(int'(a) * 'o1234 + 5);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
    end
  endtask

  // monitor and responder: decides readiness at the negative edge
  bit            mhold = 1'b0, ehold = 1'b0;
  logic [AW-1:0] h_addr, h_ea;
  logic          h_we;
  logic [W-1:0]  h_wd;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      ea_ready  = 1'b0;
      mhold = 1'b0;
      ehold = 1'b0;
    end else begin
      if (mhold)
        check(mem_req && mem_addr == h_addr && mem_we == h_we && mem_wdata == h_wd,
              "R9", "held access", longint'(mem_addr), longint'(h_addr));
      if (ehold)
        check(ea_valid && ea == h_ea, "R10", "held result",
              longint'(ea), longint'(h_ea));
      mem_ready = ($urandom_range(0, 2) != 0);
      ea_ready  = ($urandom_range(0, 2) != 0);
      mem_rdata = peek(mem_addr);
      if (mem_req && mem_ready) begin
        if (acc_q.size() == 0) begin
          check(1'b0, "R9", "unexpected access", longint'(mem_addr), 0);
        end else begin
          acc_t e;
          e = acc_q.pop_front();
          check(mem_addr == e.addr && mem_we == e.we && (!e.we || mem_wdata == e.data),
                e.tag, e.we ? "write access" : "read access",
                e.we ? longint'(mem_wdata) : longint'(mem_addr),
                e.we ? longint'(e.data) : longint'(e.addr));
          if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        end
      end
      if (ea_valid && ea_ready) begin
        if (ea_q.size() == 0) begin
          check(1'b0, "R10", "unexpected result", longint'(ea), 0);
        end else begin
          logic [AW-1:0] x;
          string t;
          x = ea_q.pop_front();
          t = tag_q.pop_front();
          check(ea == x && acc_q.size() == 0, t, "address",
                longint'(ea), longint'(x));
        end
      end
      mhold  = mem_req && !mem_ready;
      h_addr = mem_addr;
      h_we   = mem_we;
      h_wd   = mem_wdata;
      ehold  = ea_valid && !ea_ready;
      h_ea   = ea;
    end
  end

  // behavioural model + driver for one request
  task automatic send(input logic [W-1:0] ins, input logic [W-1:0] pc,
                      input logic bm, input logic [W-1:0] xr);
    logic [W-1:0] near, base, p, n;
    logic [12:0]  op;
    logic         ind, idx, ai;
    string        tag;
    acc_t         e;
    near = bm ? ((pc & 18'o760000) | (ins & 18'o017777))
              : ((pc & 18'o770000) | (ins & 18'o007777));
    ind  = ins[13];
    idx  = !bm && ins[12];
    op   = bm ? ins[12:0] : {1'b0, ins[11:0]};
    ai   = ind && (op >= 13'd8) && (op <= 13'd15);
    base = near;
    tag  = bm ? (ins[12] ? "R8" : "R2") : "R1";
    if (ai) begin
      p = peek(AW'(op));
      n = p + 1'b1;
      e.addr = AW'(op); e.we = 1'b0; e.data = '0; e.tag = "R4";
      acc_q.push_back(e);
      e.we = 1'b1; e.data = n; e.tag = "R5";
      acc_q.push_back(e);
      base = n;
      tag  = "R5";
    end else if (ind) begin
      p = peek(near[AW-1:0]);
      e.addr = near[AW-1:0]; e.we = 1'b0; e.data = '0; e.tag = "R3";
      acc_q.push_back(e);
      base = {1'b0, pc[16:15], p[14:0]};
      tag  = "R3";
    end
    if (idx) begin
      base = base + xr;
      tag  = ind ? "R7" : "R6";
    end
    ea_q.push_back(base[AW-1:0]);
    tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_instr = ins;
    req_pc = pc;
    req_bank_mode = bm;
    req_xr = xr;
    @(negedge clk);
    req_valid = 1'b0;
    while (ea_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(req_ready == 1'b1, "R11", "req_ready in reset", longint'(req_ready), 1);
    check(ea_valid == 1'b0, "R11", "ea_valid in reset", longint'(ea_valid), 0);
    check(mem_req == 1'b0, "R11", "mem_req in reset", longint'(mem_req), 0);
    rst_n = 1'b1;

    // R1: worked page-mode example, expected 273212
    send(18'o203212, 18'o274567, 1'b0, 18'o000123);
    // R2: bank direct
    send(18'o017777, 18'o364321, 1'b1, 18'o000000);
    // R8: bank mode with machine bit 5 set, index must not apply
    send(18'o010005, 18'o123456, 1'b1, 18'o000100);
    // R3: indirect, pointer upper bits dropped, block from PC
    mem[int'(17'o050100)] = 18'o777777;
    send(18'o020100, 18'o250000, 1'b0, 18'o0);
    // R5: cell wraps from 777777 to 0
    mem[8] = 18'o777777;
    send(18'o020010, 18'o344000, 1'b0, 18'o0);
    // R5: cell result crosses block, no splice (bank mode)
    mem[9] = 18'o177777;
    send(18'o020011, 18'o060000, 1'b1, 18'o0);
    // R4: same cell again is incremented again
    send(18'o020011, 18'o360000, 1'b0, 18'o0);
    // R4: operands just outside the range are plain pointers
    send(18'o020007, 18'o140000, 1'b0, 18'o0);
    send(18'o020020, 18'o140000, 1'b1, 18'o0);
    // R4: in-range operand without pointer flag is direct
    send(18'o000012, 18'o140000, 1'b0, 18'o0);
    // R6: zero operand, negative index
    send(18'o010000, 18'o040000, 1'b0, 18'o777776);
    // R6: sum truncated to 17 bits
    send(18'o010777, 18'o377000, 1'b0, 18'o001000);
    // R7: cell then index, and pointer then index
    send(18'o030012, 18'o200000, 1'b0, 18'o000005);
    send(18'o030400, 18'o320000, 1'b0, 18'o777000);

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ins, pc, xr;
      logic bm;
      ins = W'($urandom);
      pc  = W'($urandom);
      xr  = ($urandom_range(0, 1) == 0) ? W'($urandom) : W'(-$urandom_range(0, 40));
      bm  = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 2) == 0) begin
        ins[13] = 1'b1;
        if (bm) ins[12:0] = 13'(8 + $urandom_range(0, 7));
        else    ins[11:0] = 12'(8 + $urandom_range(0, 7));
      end
      send(ins, pc, bm, xr);
    end

    repeat (4) @(negedge clk);
    check(acc_q.size() == 0 && !mem_req, "R9", "leftover accesses",
          longint'(acc_q.size()), 0);
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=%0o expected=%0o", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule